// File: doc/BRIEF.md
# Auxiliary Serial Forwarding Port

This block is a small serial master that passes a 16-bit word from the local register bank to a device further down the board. The host writes a frequency change, and the block then sends the register word without any separate send command. `freqChange` is a one-cycle strobe that marks that write. On the same cycle the block captures `regWord`, which is the current value of register 05h. It then sends the word as a framed serial burst on `sClk`, `sData` and `txEnable`.

`pdTick` is a clock-enable at the phase-detector comparison rate, and it sets the serial timing. Each pulse of `pdTick` starts one serial cycle. A frame has 20 serial cycles:

- 2 leading cycles, with the enable high and the data line low.
- 16 data cycles, most significant bit first.
- 2 trailing cycles, with the enable low.

A trigger that arrives during a frame is held as one pending request. That request is sent as the next frame, directly after the current one.

Top module: `auxSerialFwd`

## Requirements
- R1: While reset is held, and just after it is released, the outputs are `sClk`=1, `sData`=0, `txEnable`=0 and `busy`=0.
- R2: `busy` is 1 in the cycle after a `freqChange` strobe. It stays 1 until the `pdTick` that closes the last serial cycle of the last queued frame. `txEnable` is never 1 while `busy` is 0.
- R3: One frame has exactly 20 serial cycles. Each serial cycle begins on a `pdTick` and gives one rising edge of `sClk`.
- R4: In serial cycles 0 and 1, `txEnable` is 1 and `sData` is 0 at the rising edge of `sClk`.
- R5: In serial cycles 2 to 17, `sData` carries the captured word at the rising edge of `sClk`. Bit 15 comes in cycle 2 and bit 0 in cycle 17, and `txEnable` is 1.
- R6: In serial cycles 18 and 19, `sClk` still pulses, `txEnable` is 0 and `sData` is 0.
- R7: Each `pdTick` during a frame makes `sClk` fall. `sClk` stays low for exactly one clock and then rises. `sData` changes only in the cycle in which `sClk` falls, so it is stable at every rising edge. This assumes that `pdTick` pulses are at least two clocks apart.
- R8: The word that is sent is the value of `regWord` in the cycle of the trigger. Changes to `regWord` after that cycle do not change the frame.
- R9: Triggers that arrive while `busy` is 1 combine into a single pending request, which carries the most recent word. That frame starts on the `pdTick` that closes the current frame, so `busy` stays high across both frames.
- R10: When there is no trigger, `pdTick` has no effect: `sClk` stays 1, `txEnable` stays 0 and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pdTick | input | 1 | Serial-rate clock-enable, at the phase-detector rate |
| freqChange | input | 1 | One-cycle strobe for a frequency-change write |
| regWord | input | 16 | Current value of register 05h |
| sClk | output | 1 | Serial clock to the downstream device; idles high |
| sData | output | 1 | Serial data, sent most significant bit first |
| txEnable | output | 1 | Frame enable to the downstream device, active high |
| busy | output | 1 | High while a frame is queued or in progress |

## Verification
Two things can land in the same cycle: a new trigger and the `pdTick` that closes a frame. A trigger can also arrive while the frame is shifting. In that case it must be queued behind the frame, and the queued request must start on the closing tick. The bench raises two triggers during one frame. It then checks that exactly 40 rising clock edges follow. It checks that the first frame carries the first word and the second frame carries only the later word. It also checks that `busy` never drops between the two frames. Every frame is decoded at the rising edges of `sClk`, and a monitor flags any change of `sData` that is not at a falling edge.

// File: rtl/auxSerialFwd_pkg.sv
package auxSerialFwd_pkg;
  typedef struct packed {
    logic capture;    // latch regWord into holding register
    logic launch;     // move holding register into shifter, slot 0 begins
    logic slotStart;  // a serial cycle begins: drop sClk, update data/enable
    logic emit;       // new slot is a data slot
    logic frameOn;    // new slot keeps txEnable asserted
  } ctrlStrb_t;
endpackage

// File: rtl/auxSerialFwd_ctrl.sv
module auxSerialFwd_ctrl
  import auxSerialFwd_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LEAD   = 2,
  parameter int TRAIL  = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pdTick,
  input  logic      freqChange,
  output ctrlStrb_t strb,
  output logic      busy
);
  localparam int SLOTS = LEAD + WORD_W + TRAIL;
  localparam int CNT_W = $clog2(SLOTS);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS - 1);
  localparam logic [CNT_W-1:0] DATA_LO   = CNT_W'(LEAD);
  localparam logic [CNT_W-1:0] DATA_END  = CNT_W'(LEAD + WORD_W);

  logic             pending, active;
  logic [CNT_W-1:0] slot, nextSlot;
  logic             lastSlot, launch, advance;

  always_comb begin
    lastSlot = active && (slot == LAST_SLOT);
    launch   = pdTick && pending && (!active || lastSlot);
    advance  = pdTick && active && !lastSlot;
    nextSlot = launch ? '0 : slot + 1'b1;
    strb.capture   = freqChange;
    strb.launch    = launch;
    strb.slotStart = launch || advance;
    strb.emit      = (nextSlot >= DATA_LO) && (nextSlot < DATA_END);
    strb.frameOn   = nextSlot < DATA_END;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      active  <= 1'b0;
      slot    <= '0;
    end else begin
      pending <= freqChange || (pending && !launch);
      if (launch)                 active <= 1'b1;
      else if (pdTick && lastSlot) active <= 1'b0;
      if (launch || advance)      slot <= nextSlot;
    end
  end

  assign busy = pending || active;

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    active |-> slot <= LAST_SLOT); // R3
  AST_BUSY_AFTER_TRIG: assert property (@(posedge clk) disable iff (!rstN)
    freqChange |=> busy); // R2
  AST_FRAME_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    (pdTick && lastSlot && !pending) |=> !active); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !freqChange) |=> !active); // R10
endmodule

// File: rtl/auxSerialFwd_dp.sv
module auxSerialFwd_dp
  import auxSerialFwd_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [WORD_W-1:0] regWord,
  output logic              sClk,
  output logic              sData,
  output logic              txEnable
);
  logic [WORD_W-1:0] holdWord, shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
      shiftReg <= '0;
      sClk     <= 1'b1;
      sData    <= 1'b0;
      txEnable <= 1'b0;
    end else begin
      if (strb.capture) holdWord <= regWord;
      if (strb.slotStart) begin
        sClk     <= 1'b0;
        txEnable <= strb.frameOn;
        if (strb.launch) shiftReg <= holdWord;
        if (strb.emit) begin
          sData    <= shiftReg[WORD_W-1];
          shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
        end else begin
          sData <= 1'b0;
        end
      end else begin
        sClk <= 1'b1;
      end
    end
  end

  AST_SCLK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !sClk |=> sClk); // R7
  AST_DATA_AT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sData) |-> $fell(sClk)); // R7
  AST_TRAIL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |-> !sData); // R6
endmodule

// File: rtl/auxSerialFwd.sv
module auxSerialFwd
  import auxSerialFwd_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LEAD   = 2,
  parameter int TRAIL  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pdTick,
  input  logic              freqChange,
  input  logic [WORD_W-1:0] regWord,
  output logic              sClk,
  output logic              sData,
  output logic              txEnable,
  output logic              busy
);
  ctrlStrb_t strb;

  auxSerialFwd_ctrl #(.WORD_W(WORD_W), .LEAD(LEAD), .TRAIL(TRAIL)) u_ctrl (
    .clk(clk), .rstN(rstN), .pdTick(pdTick), .freqChange(freqChange),
    .strb(strb), .busy(busy)
  );

  auxSerialFwd_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWord(regWord),
    .sClk(sClk), .sData(sData), .txEnable(txEnable)
  );

  AST_ENB_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    txEnable |-> busy); // R2
endmodule

// File: tb/auxSerialFwd_tb.sv
module auxSerialFwd_tb;
  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{16'hA5C3, 16'h0000, 16'hFFFF,
                                       16'h8001, 16'h1234, 16'h7FFE};
  localparam int MAXS = 512;

  logic clk = 0, rstN = 0, pdTick = 0, freqChange = 0;
  logic [15:0] regWord = '0;
  logic sClk, sData, txEnable, busy;

  int nRun = 0, nFail = 0;
  int nSamp = 0, edgeErr = 0, tickCnt = 0;
  logic sampD [MAXS];
  logic sampE [MAXS];
  logic prevClk = 1, prevD = 0;

  auxSerialFwd u_dut (.clk(clk), .rstN(rstN), .pdTick(pdTick), .freqChange(freqChange),
    .regWord(regWord), .sClk(sClk), .sData(sData), .txEnable(txEnable), .busy(busy));

  always #5 clk = ~clk;

  // free-running tick every 4 clocks, driven away from the active edge
  always @(negedge clk) begin
    tickCnt <= (tickCnt == 3) ? 0 : tickCnt + 1;
    pdTick  <= (tickCnt == 3);
  end

  // line monitor: decode rising sClk, watch R7 timing
  always @(negedge clk) begin
    if (rstN) begin
      if (!prevClk && sClk && nSamp < MAXS) begin
        sampD[nSamp] <= sData;
        sampE[nSamp] <= txEnable;
        nSamp <= nSamp + 1;
      end
      if (!prevClk && !sClk) edgeErr <= edgeErr + 1;
      if (sData !== prevD && !(prevClk && !sClk)) edgeErr <= edgeErr + 1;
    end
    prevClk <= sClk;
    prevD   <= sData;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic trigger(input logic [15:0] w);
    @(negedge clk);
    regWord = w;
    freqChange = 1;
    @(negedge clk);
    freqChange = 0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
    if (n >= 2000) check(0, "R2", "busy never cleared", busy, 0);
  endtask

  task automatic verifyFrame(input int base, input logic [15:0] w, input string tag);
    logic [15:0] got = '0;
    bit okLead = 1, okTrail = 1, okEn = 1;
    for (int i = 0; i < 2; i++) if (sampE[base+i] !== 1 || sampD[base+i] !== 0) okLead = 0;
    for (int i = 2; i < 18; i++) begin
      got[17-i] = sampD[base+i];
      if (sampE[base+i] !== 1) okEn = 0;
    end
    for (int i = 18; i < 20; i++) if (sampE[base+i] !== 0 || sampD[base+i] !== 0) okTrail = 0;
    check(okLead, "R4", {tag, " lead cycles"}, okLead, 1);
    check(got === w && okEn, "R5", {tag, " data MSB first"}, got, w);
    check(okTrail, "R6", {tag, " trail cycles"}, okTrail, 1);
  endtask

  initial begin
    #2_000_000;
    check(0, "R2", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int base;
    int busyDrop;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(sClk === 1 && sData === 0 && txEnable === 0 && busy === 0, "R1", "in reset",
          {sClk, sData, txEnable, busy}, 4'b1000);
    rstN = 1;
    repeat (2) @(negedge clk);
    check(sClk === 1 && sData === 0 && txEnable === 0 && busy === 0, "R1", "after reset",
          {sClk, sData, txEnable, busy}, 4'b1000);

    // R10 ticks alone do nothing
    base = nSamp;
    busyDrop = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (busy || txEnable || !sClk) busyDrop++;
    end
    check(busyDrop == 0 && nSamp == base, "R10", "idle activity", nSamp - base, 0);

    // table of words: full frame per vector
    for (int v = 0; v < NV; v++) begin
      base = nSamp;
      trigger(VEC[v]);
      check(busy === 1, "R2", "busy after trigger", busy, 1);
      waitIdle();
      check(nSamp - base == 20, "R3", "serial cycles per frame", nSamp - base, 20);
      verifyFrame(base, VEC[v], "vector");
      check(txEnable === 0 && sClk === 1, "R2", "idle after frame", {txEnable, sClk}, 2'b01);
    end

    // R8: regWord changed after trigger has no effect
    base = nSamp;
    trigger(16'hC0DE);
    regWord = 16'h3F21;
    repeat (30) @(negedge clk);
    regWord = 16'h0F0F;
    waitIdle();
    check(nSamp - base == 20, "R8", "frame length", nSamp - base, 20);
    verifyFrame(base, 16'hC0DE, "R8 latched");

    // R9: two triggers during a frame merge into one queued frame
    base = nSamp;
    trigger(16'h9ABC);
    repeat (20) @(negedge clk);
    trigger(16'h1111);
    repeat (8) @(negedge clk);
    trigger(16'h6D2E);
    busyDrop = 0;
    for (int i = 0; i < 400 && nSamp < base + 40; i++) begin
      @(negedge clk);
      if (!busy) busyDrop++;
    end
    check(busyDrop == 0, "R9", "busy held across frames", busyDrop, 0);
    waitIdle();
    check(nSamp - base == 40, "R9", "two frames only", nSamp - base, 40);
    verifyFrame(base, 16'h9ABC, "R9 first");
    verifyFrame(base + 20, 16'h6D2E, "R9 merged");

    // R7 timing observed over the whole run
    check(edgeErr == 0, "R7", "sClk width / data edge violations", edgeErr, 0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule